// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the SPI slave front end of a small byte-wide nonvolatile memory. The storage itself is modelled as 512 on-chip byte registers. A host selects the block with an active-low chip select and clocks in an 8-bit opcode. For array reads and writes, the host then sends an address byte. The ninth address bit is carried inside the opcode. A read streams bytes out from incrementing addresses. A write collects up to a page of bytes in a buffer and commits them when chip select rises.

The SPI pins are sampled on the system clock. The block detects SCK edges itself, so the SPI clock must run well below the system clock, and no second clock domain is needed. The block also holds a write-enable latch and a small status register. Two of the status fields, a watchdog setting and a block-lock setting, are driven out as plain outputs for neighbouring logic. After every commit, a busy interval of `BUSY_CYC` system clocks models the programming time.

Top module: `spi_nvm_slave`

## Requirements
- R1: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Each takes effect once its eighth bit has been received.
- R2: Opcode 0x05 returns the status byte repeatedly for as long as SCK runs. The status byte has bits 7:6 = 0, bits 5:4 = watchdog field, bits 3:2 = lock field, bit 1 = write-enable latch and bit 0 = write in progress. SO is held low whenever chip select is high.
- R3: A read opcode is 0000_A011, where opcode bit 3 supplies address bit 8, and it is followed by the low address byte. Data then leaves MSB first, one bit per SCK falling edge. The address increments after every byte and wraps from 0x1FF to 0x000.
- R4: A write opcode (0000_A010) or status-write opcode (0x01) has no effect on memory or status unless the write-enable latch was set when the opcode was received.
- R5: A write commits only when chip select rises on a byte boundary after at least one data byte. A transfer cut off inside a byte leaves memory and the latch unchanged.
- R6: Write bytes fill an aligned 16-byte page starting at the given address, and the offset wraps inside that page. Bytes beyond the sixteenth overwrite the earliest ones.
- R7: The write-enable latch clears when an accepted write or status write commits.
- R8: Write in progress reads 1 from a commit until `BUSY_CYC` clocks have passed. A write or status write whose opcode arrives in that interval is rejected.
- R9: A status write takes data bits 5:4 as the watchdog field and bits 3:2 as the lock field. It updates them only at commit, and `wdog_sel` and `lock_sel` show the fields.
- R10: SCK may pause for any time with chip select low, and the transfer then continues from the next bit.
- R11: After reset, memory and status read as zero and SO is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SPI pins are sampled on it |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in, sampled on SCK rising edges |
| so | output | 1 | Serial data out, changed on SCK falling edges |
| wdog_sel | output | 2 | Watchdog setting field of the status register |
| lock_sel | output | 2 | Block-lock setting field of the status register |

## Verification
The assertions check four things on every cycle. Status fields change only in the cycle after chip select rises. A busy interval starts only at such a rise, and it begins with the latch already cleared. The protection fields cannot change while a commit is in progress. SO stays low while the device is deselected.

Other behaviour can only be shown by the bench's scenarios, run against an arithmetic model. The bench sweeps all 512 locations through page writes at rotating start offsets, then reads everything back in a single burst that crosses the top address. It also covers the over-long page burst, the transfer cut off inside a byte, rejection of writes without the latch and during the busy interval, and a long SCK pause.

// File: rtl/spi_nvm_slave.sv
module spi_nvm_slave #(
  parameter int PAGE     = 16,
  parameter int BUSY_CYC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       si,
  output logic       so,
  output logic [1:0] wdog_sel,
  output logic [1:0] lock_sel
);
  localparam int AW    = 9;
  localparam int DEPTH = 1 << AW;
  localparam int PW    = $clog2(PAGE);
  localparam int BW    = $clog2(BUSY_CYC + 1);

  typedef enum logic [2:0] {P_OP, P_ADDR, P_WDAT, P_RDAT, P_SDAT, P_RSTAT, P_IGN} phase_t;

  logic [2:0] sck_p, cs_p;
  logic [1:0] si_p;
  phase_t     phase;
  logic [2:0] bcnt, ocnt;
  logic [7:0] sh, osh;
  logic       rd_op, a8, wel, sval;
  logic [AW-1:0] addr;
  logic [3:0] prot, sbuf;
  logic [BW-1:0] busy;
  logic [7:0] pbuf [PAGE];
  logic [PAGE-1:0] pval;
  logic [PW-1:0] ptr;
  logic [7:0] mem [DEPTH];

  wire rise    = sck_p[1] & ~sck_p[2];
  wire fall    = ~sck_p[1] & sck_p[2];
  wire cs_hi   = cs_p[1];
  wire cs_rise = cs_p[1] & ~cs_p[2];
  wire [7:0] nb = {sh[6:0], si_p[1]};
  wire wip     = busy != '0;
  wire wr_ok   = wel & ~wip;
  wire [7:0] status = {2'b00, prot, wel, wip};
  wire reading = (phase == P_RDAT) || (phase == P_RSTAT);

  assign so       = reading & osh[7];
  assign wdog_sel = prot[3:2];
  assign lock_sel = prot[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_p <= '0; cs_p <= '1; si_p <= '0;
      phase <= P_OP; bcnt <= '0; ocnt <= '0; sh <= '0; osh <= '0;
      rd_op <= 1'b0; a8 <= 1'b0; wel <= 1'b0; sval <= 1'b0;
      addr <= '0; prot <= '0; sbuf <= '0; busy <= '0;
      pval <= '0; ptr <= '0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      sck_p <= {sck_p[1:0], sck};
      cs_p  <= {cs_p[1:0], cs_n};
      si_p  <= {si_p[0], si};
      if (wip) busy <= busy - BW'(1);
      if (cs_hi) begin
        if (cs_rise && bcnt == '0) begin
          if (phase == P_WDAT && pval != '0) begin
            for (int i = 0; i < PAGE; i++)
              if (pval[i]) mem[{addr[AW-1:PW], PW'(i)}] <= pbuf[i];
            wel  <= 1'b0;
            busy <= BW'(BUSY_CYC);
          end
          if (phase == P_SDAT && sval) begin
            prot <= sbuf;
            wel  <= 1'b0;
            busy <= BW'(BUSY_CYC);
          end
        end
        phase <= P_OP; bcnt <= '0; ocnt <= '0; osh <= '0;
        pval <= '0; sval <= 1'b0;
      end else begin
        if (rise) begin
          sh   <= nb;
          bcnt <= bcnt + 3'd1;
          if (bcnt == 3'd7) begin
            case (phase)
              P_OP: begin
                if (nb[7:4] == 4'h0 && nb[2:1] == 2'b01) begin
                  a8    <= nb[3];
                  rd_op <= nb[0];
                  phase <= (nb[0] || wr_ok) ? P_ADDR : P_IGN;
                end else if (nb == 8'h06) begin
                  wel <= 1'b1; phase <= P_IGN;
                end else if (nb == 8'h04) begin
                  wel <= 1'b0; phase <= P_IGN;
                end else if (nb == 8'h05) begin
                  phase <= P_RSTAT;
                end else if (nb == 8'h01) begin
                  phase <= wr_ok ? P_SDAT : P_IGN;
                end else begin
                  phase <= P_IGN;
                end
              end
              P_ADDR: begin
                addr  <= {a8, nb};
                ptr   <= nb[PW-1:0];
                phase <= rd_op ? P_RDAT : P_WDAT;
              end
              P_WDAT: begin
                pbuf[ptr] <= nb;
                pval[ptr] <= 1'b1;
                ptr       <= ptr + PW'(1);
              end
              P_SDAT: begin
                sbuf <= nb[5:2];
                sval <= 1'b1;
              end
              default: ;
            endcase
          end
        end
        if (fall && reading) begin
          ocnt <= ocnt + 3'd1;
          if (ocnt == '0) begin
            if (phase == P_RDAT) begin
              osh  <= mem[addr];
              addr <= addr + AW'(1);
            end else begin
              osh <= status;
            end
          end else begin
            osh <= {osh[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

module spi_nvm_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_hi,
  input logic       cs_rise,
  input logic       wel,
  input logic       wip,
  input logic [3:0] prot,
  input logic       so
);
  assert_status_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot) |-> $past(cs_rise));
  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(cs_rise));
  assert_busy_locks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wip) |-> $stable(prot));
  assert_latch_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> !wel);
  assert_quiet_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi && $past(cs_hi)) |-> !so);
endmodule

bind spi_nvm_slave spi_nvm_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .cs_rise(cs_rise),
  .wel(wel), .wip(wip), .prot(prot), .so(so)
);

// File: tb/tb_spi_nvm_slave.sv
module tb_spi_nvm_slave;
  localparam int BUSY = 600;
  localparam int HP   = 4;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so;
  logic [1:0] wdog_sel, lock_sel;
  int nvec = 0, nerr = 0;
  logic [7:0] mm [512];

  always #2 clk = ~clk;

  spi_nvm_slave #(.PAGE(16), .BUSY_CYC(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .so(so), .wdog_sel(wdog_sel), .lock_sel(lock_sel));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, input int pause_bit);
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      tick(HP);
      rx[i] = so;
      sck = 1'b1;
      tick(HP);
      sck = 1'b0;
      if (i == pause_bit) tick(300);
    end
  endtask

  task automatic sel();
    cs_n = 1'b0; tick(HP);
  endtask

  task automatic desel();
    tick(HP); cs_n = 1'b1; tick(2 * HP);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] rx;
    sel(); xbyte(op, rx, -1); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] rx;
    sel(); xbyte(8'h05, rx, -1); xbyte(8'h00, s, -1); desel();
  endtask

  task automatic wrsr(input logic [7:0] d);
    logic [7:0] rx;
    sel(); xbyte(8'h01, rx, -1); xbyte(d, rx, -1); desel();
  endtask

  task automatic wr(input int a, input int n, input int base, input bit upd);
    logic [7:0] rx, d;
    sel();
    xbyte({4'h0, 1'(a >> 8), 3'b010}, rx, -1);
    xbyte(8'(a), rx, -1);
    for (int k = 0; k < n; k++) begin
      d = 8'(base + k * 13);
      xbyte(d, rx, -1);
      if (upd) mm[{9'(a) & 9'h1F0} | 9'((a + k) % 16)] = d;
    end
    desel();
  endtask

  task automatic rd_chk(input int a, input int n, input string tag, input int pause_k);
    logic [7:0] rx;
    sel();
    xbyte({4'h0, 1'(a >> 8), 3'b011}, rx, -1);
    xbyte(8'(a), rx, -1);
    for (int k = 0; k < n; k++) begin
      xbyte(8'h00, rx, (k == pause_k) ? 3 : -1);
      chk(tag, rx, mm[(a + k) % 512]);
    end
    desel();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] s, rx;
    for (int i = 0; i < 512; i++) mm[i] = 8'h00;
    tick(5); rst_n = 1'b1; tick(5);

    // R11 reset state
    chk("R11 so", {7'd0, so}, 8'h00);
    chk("R11 fields", {4'd0, wdog_sel, lock_sel}, 8'h00);
    rdsr(s); chk("R11 status", s, 8'h00);
    rd_chk(9'h010, 2, "R11 memory", -1);

    // R4 writes without latch
    wr(9'h010, 1, 8'hAA, 0);
    rd_chk(9'h010, 1, "R4 write ignored", -1);
    wrsr(8'hFF);
    rdsr(s); chk("R4 status write ignored", s, 8'h00);
    chk("R4 fields", {4'd0, wdog_sel, lock_sel}, 8'h00);

    // R1 latch control
    cmd1(8'h06); rdsr(s); chk("R1 set latch", s, 8'h02);
    cmd1(8'h04); rdsr(s); chk("R1 clear latch", s, 8'h00);

    // R6 R7 R8 sweep all pages at rotating offsets
    for (int p = 0; p < 32; p++) begin
      cmd1(8'h06);
      wr(p * 16 + (p % 16), 16, p * 7 + 1, 1);
      rdsr(s); chk("R7 R8 after commit", s & 8'h03, 8'h01);
      tick(BUSY + 20);
    end
    rdsr(s); chk("R8 busy ends", s, 8'h00);

    // R3 full burst crossing the top address
    rd_chk(0, 514, "R3 burst wrap", -1);
    rd_chk(9'h180, 3, "R3 opcode address bit", -1);

    // R6 more than a page
    cmd1(8'h06);
    wr(9'h0A5, 20, 8'h40, 1);
    tick(BUSY + 20);
    rd_chk(9'h0A0, 16, "R6 overwrite earliest", -1);

    // R5 abort inside a byte
    cmd1(8'h06);
    sel();
    xbyte(8'h02, rx, -1); xbyte(8'h30, rx, -1); xbyte(8'hEE, rx, -1);
    for (int i = 0; i < 3; i++) begin
      si = 1'b1; tick(HP); sck = 1'b1; tick(HP); sck = 1'b0;
    end
    desel();
    rdsr(s); chk("R5 latch kept", s, 8'h02);
    rd_chk(9'h030, 1, "R5 no commit", -1);
    cmd1(8'h04);

    // R9 status write
    cmd1(8'h06); wrsr(8'hFF);
    rdsr(s); chk("R9 R7 status", s, 8'h3D);
    chk("R9 fields", {4'd0, wdog_sel, lock_sel}, 8'h0F);
    tick(BUSY + 20);
    cmd1(8'h06); wrsr(8'h24);
    tick(BUSY + 20);
    rdsr(s); chk("R9 status second", s, 8'h24);
    chk("R9 wdog", {6'd0, wdog_sel}, 8'h02);
    chk("R9 lock", {6'd0, lock_sel}, 8'h01);

    // R8 write rejected while busy
    cmd1(8'h06);
    wr(9'h040, 1, 8'h5A, 1);
    cmd1(8'h06);
    wr(9'h040, 1, 8'hC3, 0);
    tick(BUSY + 20);
    rd_chk(9'h040, 1, "R8 busy reject", -1);
    rdsr(s); chk("R8 latch after reject", s, 8'h26);
    cmd1(8'h04);

    // R10 SCK pause mid byte
    rd_chk(9'h1FC, 6, "R10 pause", 2);

    finish_run();
  end
endmodule